// File: doc/BRIEF.md
# Oversampling Serial Receiver with Holding Buffer

This block turns an asynchronous serial line into bytes. A tick enable at sixteen times the bit rate drives all of its timing. The line first passes through a two-stage synchronizer. A falling edge then starts a frame, and a confirmation sample taken half a bit later either accepts the start or rejects it as a glitch. The data bits, an optional parity bit and the stop bits follow. Each one is sampled once, at the centre of its bit.

Several settings are taken from configuration inputs while the block runs: seven or eight data bits, parity on or off, even or odd parity, and one or two stop bits. A finished character is copied into a one-entry holding buffer. A new frame can then be received while software has not yet collected the previous byte. The buffer-full indication, the parity, framing and overrun flags, and a one-cycle interrupt pulse all update together at the centre of the first stop bit. A read strobe empties the buffer.

Top module: `uart_rx_core`

## Requirements
- R1: After a synchronous active-low reset, `rx_data` is 0x00, and `buf_full`, `parity_err`, `frame_err`, `overrun_err` and `rx_irq` are all 0.
- R2: The line passes through two flip-flops before use. A low level seen on a tick while idle opens a start bit. The start bit is confirmed only if the line is still low on the 8th following tick. Otherwise the receiver returns to idle and delivers no byte.
- R3: Data bits arrive least significant bit first. They are sampled every 16 ticks after the start-bit confirmation. With `cfg_eight_bits`=1, eight bits are taken into `rx_data[7:0]`.
- R4: With `cfg_eight_bits`=0, seven bits are taken into `rx_data[6:0]`, and `rx_data[7]` reads as 0.
- R5: With `cfg_parity_en`=1, one parity bit follows the data. `cfg_parity_odd`=0 expects an even count of ones over the data and parity bits, and 1 expects an odd count. A mismatch sets `parity_err` for that byte. With `cfg_parity_en`=0, no parity bit is present and `parity_err` is 0.
- R6: `frame_err` is 1 for a byte whose first stop bit samples as 0.
- R7: A byte completes at the centre of its first stop bit, in both 1-stop and 2-stop mode. The second stop bit is waited out but not checked. On completion into an empty buffer, the byte is loaded, `buf_full` becomes 1 and `rx_irq` is high for exactly one cycle.
- R8: A cycle with `rd_strobe`=1 and no completing byte clears `buf_full` to 0. It leaves `rx_data` and the error flags unchanged.
- R9: If a byte completes while `buf_full`=1 and `rd_strobe`=0, `overrun_err` becomes 1 and no interrupt is raised. `rx_data`, `parity_err` and `frame_err` keep the values of the stored byte. The next byte accepted into the buffer clears `overrun_err`.
- R10: If a byte completes in the same cycle as `rd_strobe`=1, the new byte is accepted and `buf_full` stays 1. `overrun_err` is 0 and `rx_irq` pulses.
- R11: The receiver's frame position advances only in cycles where `tick16`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Enable at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_eight_bits | input | 1 | 1: eight data bits, 0: seven |
| cfg_parity_en | input | 1 | 1: parity bit present |
| cfg_parity_odd | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop | input | 1 | 1: two stop bits |
| rd_strobe | input | 1 | Buffer read, empties the buffer |
| rx_data | output | 8 | Holding buffer contents |
| buf_full | output | 1 | Buffer holds an unread byte |
| parity_err | output | 1 | Parity mismatch on stored byte |
| frame_err | output | 1 | First stop bit of stored byte was low |
| overrun_err | output | 1 | A byte was lost because the buffer was full |
| rx_irq | output | 1 | One-cycle pulse when a byte is loaded |

## Verification
Frames are sent in 8N1, 8E1, 8O1 with a corrupted parity bit, 7N2 and 8N2 with a low second stop bit. Together these separate the bit ordering, the character length, the parity sense and the point at which completion happens. A frame with a low first stop bit and a four-cycle low glitch separate a framing error from a rejected false start. Back-to-back unread bytes, and a read that lands exactly on the completion cycle, separate an overrun from a clean hand-over. A run with one tick every three clocks shows that timing follows the tick and not the clock. A behavioural receiver model in the bench is compared with every output on every clock.

// File: rtl/uart_rx_pkg.sv
// Shared types for the serial receiver.
// Assumes characters of at most RX_MAX_BITS data bits.
package uart_rx_pkg;

    parameter int unsigned RX_MAX_BITS = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP1,
        RX_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [RX_MAX_BITS-1:0] data;
        logic                   par_err;
        logic                   frm_err;
    } rx_frame_t;

endpackage

// File: rtl/rx_line_sync.sv
// Multi-stage synchronizer for the asynchronous serial line.
// Assumes the line idles high; every stage resets to 1 so that no false
// start is seen when reset is released.
module rx_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_sync
);

    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage register of the line.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= line_in;
            end
        end else begin : g_chain
            // Shift the line through the stage chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[STAGES-2:0], line_in};
            end
        end
    endgenerate

    assign line_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
// Frame sequencer: start validation, centre sampling of data, parity and
// stop bits, and a one-cycle completion strobe at the first stop bit centre.
// Assumes line_s is already synchronous and that the configuration inputs
// are held steady for the length of a frame.
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16,
    parameter int unsigned MAX_BITS   = RX_MAX_BITS
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      line_s,
    input  logic      cfg_eight,
    input  logic      cfg_par_en,
    input  logic      cfg_par_odd,
    input  logic      cfg_two_stop,
    output logic      frame_done,
    output rx_frame_t frame_out
);

    localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
    localparam int unsigned IDX_W = $clog2(MAX_BITS);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] IDX_LONG  = IDX_W'(MAX_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(MAX_BITS - 2);

    rx_state_e           state;
    logic [CNT_W-1:0]    cnt;
    logic [IDX_W-1:0]    idx;
    logic [MAX_BITS-1:0] shreg;
    logic                pbit;
    logic                at_mid;
    logic                at_last;
    logic [IDX_W-1:0]    last_idx;

    // Decode the tick counter positions and the final data bit index.
    always_comb begin
        at_mid   = (cnt == CNT_MID);
        at_last  = (cnt == CNT_LAST);
        last_idx = cfg_eight ? IDX_LONG : IDX_SHORT;
    end

    // Completion strobe and the character with its error checks.
    always_comb begin
        frame_done        = tick && (state == RX_STOP1) && at_last;
        frame_out.data    = shreg;
        frame_out.par_err = cfg_par_en && ((^shreg ^ pbit) != cfg_par_odd);
        frame_out.frm_err = !line_s;
    end

    // Step the frame sequence on each oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
        end else if (tick) begin
            unique case (state)
                RX_IDLE: begin
                    if (!line_s) begin
                        state <= RX_START;
                        cnt   <= '0;
                    end
                end
                RX_START: begin
                    if (at_mid) begin
                        cnt <= '0;
                        if (!line_s) begin
                            state <= RX_DATA;
                            idx   <= '0;
                            shreg <= '0;
                            pbit  <= 1'b0;
                        end else begin
                            state <= RX_IDLE;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                RX_DATA: begin
                    if (at_last) begin
                        cnt        <= '0;
                        shreg[idx] <= line_s;
                        if (idx == last_idx) begin
                            state <= cfg_par_en ? RX_PARITY : RX_STOP1;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                RX_PARITY: begin
                    if (at_last) begin
                        cnt   <= '0;
                        pbit  <= line_s;
                        state <= RX_STOP1;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                RX_STOP1: begin
                    if (at_last) begin
                        cnt   <= '0;
                        state <= cfg_two_stop ? RX_STOP2 : RX_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                RX_STOP2: begin
                    if (at_last) begin
                        cnt   <= '0;
                        state <= RX_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    state <= RX_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R2: a start that reads high at its mid sample falls back to idle.
    a_r2_false_start_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && tick && at_mid && line_s) |=> (state == RX_IDLE));

    // R11: without a tick the sequencer holds its position.
    a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(state) && $stable(cnt) && $stable(idx)));

    // R4: a seven-bit character never carries a set top bit.
    a_r4_short_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !cfg_eight) |-> !frame_out.data[MAX_BITS-1]);

    // R7: a completion is followed by the optional second stop or idle.
    a_r7_after_first_stop: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (state == RX_STOP2 || state == RX_IDLE));

endmodule

// File: rtl/rx_buffer_flags.sv
// One-entry holding buffer with full, error and overrun flags and the
// receive interrupt pulse.
// Assumes frame_done is a one-cycle strobe, never on consecutive cycles.
module rx_buffer_flags
    import uart_rx_pkg::*;
#(
    parameter int unsigned MAX_BITS = RX_MAX_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_done,
    input  rx_frame_t           frame_in,
    input  logic                rd_strobe,
    output logic [MAX_BITS-1:0] buf_data,
    output logic                buf_full,
    output logic                par_err,
    output logic                frm_err,
    output logic                ovr_err,
    output logic                irq
);

    logic accept;

    // A byte is taken when the buffer is empty or is being read now.
    always_comb accept = frame_done && (!buf_full || rd_strobe);

    // Load, drain and flag update of the holding buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_data <= '0;
            buf_full <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
            ovr_err  <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq <= accept;
            if (accept) begin
                buf_data <= frame_in.data;
                buf_full <= 1'b1;
                par_err  <= frame_in.par_err;
                frm_err  <= frame_in.frm_err;
                ovr_err  <= 1'b0;
            end else if (frame_done) begin
                ovr_err <= 1'b1;
            end else if (rd_strobe) begin
                buf_full <= 1'b0;
            end
        end
    end

    // R8: a plain read empties the buffer on the next cycle.
    a_r8_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !frame_done) |=> !buf_full);

    // R7: the interrupt only accompanies a full buffer.
    a_r7_irq_means_full: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> buf_full);

    // R7: the interrupt is a single-cycle pulse.
    a_r7_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: an unread buffer keeps its byte and flags the loss.
    a_r9_overrun_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && buf_full && !rd_strobe) |=> (ovr_err && $stable(buf_data) && !irq));

    // R10: a read on the completion cycle hands over with no loss.
    a_r10_read_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && buf_full && rd_strobe) |=> (buf_full && !ovr_err && irq));

endmodule

// File: rtl/uart_rx_core.sv
// Top of the serial receiver: synchronizer, frame sequencer and holding
// buffer. Assumes tick16 is a one-cycle enable at sixteen times the bit
// rate and that configuration changes only between frames.
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick16,
    input  logic                   rx_line,
    input  logic                   cfg_eight_bits,
    input  logic                   cfg_parity_en,
    input  logic                   cfg_parity_odd,
    input  logic                   cfg_two_stop,
    input  logic                   rd_strobe,
    output logic [RX_MAX_BITS-1:0] rx_data,
    output logic                   buf_full,
    output logic                   parity_err,
    output logic                   frame_err,
    output logic                   overrun_err,
    output logic                   rx_irq
);

    logic      line_s;
    logic      frame_done;
    rx_frame_t frame_word;

    rx_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (rx_line),
        .line_sync (line_s)
    );

    rx_frame_fsm #(
        .OVERSAMPLE (OVERSAMPLE),
        .MAX_BITS   (RX_MAX_BITS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick16),
        .line_s       (line_s),
        .cfg_eight    (cfg_eight_bits),
        .cfg_par_en   (cfg_parity_en),
        .cfg_par_odd  (cfg_parity_odd),
        .cfg_two_stop (cfg_two_stop),
        .frame_done   (frame_done),
        .frame_out    (frame_word)
    );

    rx_buffer_flags #(
        .MAX_BITS (RX_MAX_BITS)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_in   (frame_word),
        .rd_strobe  (rd_strobe),
        .buf_data   (rx_data),
        .buf_full   (buf_full),
        .par_err    (parity_err),
        .frm_err    (frame_err),
        .ovr_err    (overrun_err),
        .irq        (rx_irq)
    );

endmodule

// File: tb/tb_uart_rx_core.sv
// Bench: directed frames plus a behavioural receiver model compared with
// every output on every clock.
module tb_uart_rx_core;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic       cfg_eight_bits = 1'b1;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_parity_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rx_data;
    logic       buf_full, parity_err, frame_err, overrun_err, rx_irq;

    int tests = 0;
    int fails = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_core dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick16         (tick16),
        .rx_line        (rx_line),
        .cfg_eight_bits (cfg_eight_bits),
        .cfg_parity_en  (cfg_parity_en),
        .cfg_parity_odd (cfg_parity_odd),
        .cfg_two_stop   (cfg_two_stop),
        .rd_strobe      (rd),
        .rx_data        (rx_data),
        .buf_full       (buf_full),
        .parity_err     (parity_err),
        .frame_err      (frame_err),
        .overrun_err    (overrun_err),
        .rx_irq         (rx_irq)
    );

    // Tick enable, one in every tick_div clocks, driven off the edge.
    always @(negedge clk) begin
        tick16   <= (tick_cnt == 0);
        tick_cnt <= (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
    end

    // ---------------- behavioural model ----------------
    int         m_st = 0, m_cnt = 0, m_idx = 0;
    logic [7:0] m_sh = 0, m_data = 0;
    logic       m_pb = 0, m_s1 = 1, m_s2 = 1;
    logic       m_full = 0, m_pe = 0, m_fe = 0, m_ov = 0, m_irq = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_idx = 0; m_sh = 0; m_pb = 0;
            m_s1 = 1; m_s2 = 1;
            m_data = 0; m_full = 0; m_pe = 0; m_fe = 0; m_ov = 0; m_irq = 0;
        end else begin
            bit   done;
            logic d_fe;
            done = 0;
            d_fe = 0;
            if (tick16) begin
                case (m_st)
                    0: if (!m_s2) begin m_st = 1; m_cnt = 0; end
                    1: if (m_cnt == 7) begin
                           m_cnt = 0;
                           if (!m_s2) begin m_st = 2; m_idx = 0; m_sh = 0; m_pb = 0; end
                           else m_st = 0;
                       end else m_cnt++;
                    2: if (m_cnt == 15) begin
                           m_cnt = 0;
                           m_sh[m_idx] = m_s2;
                           if (m_idx == (cfg_eight_bits ? 7 : 6)) m_st = cfg_parity_en ? 3 : 4;
                           else m_idx++;
                       end else m_cnt++;
                    3: if (m_cnt == 15) begin m_cnt = 0; m_pb = m_s2; m_st = 4; end
                       else m_cnt++;
                    4: if (m_cnt == 15) begin
                           m_cnt = 0; done = 1; d_fe = !m_s2;
                           m_st = cfg_two_stop ? 5 : 0;
                       end else m_cnt++;
                    default: if (m_cnt == 15) begin m_cnt = 0; m_st = 0; end
                             else m_cnt++;
                endcase
            end
            m_irq = 0;
            if (done) begin
                if (!m_full || rd) begin
                    m_data = m_sh; m_full = 1; m_fe = d_fe; m_ov = 0; m_irq = 1;
                    m_pe = cfg_parity_en && ((^m_sh ^ m_pb) != cfg_parity_odd);
                end else m_ov = 1;
            end else if (rd) m_full = 0;
            m_s2 = m_s1;
            m_s1 = rx_line;
        end
    end

    // Compare every output with the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit bad;
            bad = 0;
            tests++;
            if (rx_data !== m_data) begin bad = 1; $display("FAIL R3 rx_data got %h exp %h t=%0t", rx_data, m_data, $time); end
            if (buf_full !== m_full) begin bad = 1; $display("FAIL R7 buf_full got %b exp %b t=%0t", buf_full, m_full, $time); end
            if (parity_err !== m_pe) begin bad = 1; $display("FAIL R5 parity_err got %b exp %b t=%0t", parity_err, m_pe, $time); end
            if (frame_err !== m_fe) begin bad = 1; $display("FAIL R6 frame_err got %b exp %b t=%0t", frame_err, m_fe, $time); end
            if (overrun_err !== m_ov) begin bad = 1; $display("FAIL R9 overrun_err got %b exp %b t=%0t", overrun_err, m_ov, $time); end
            if (rx_irq !== m_irq) begin bad = 1; $display("FAIL R7 rx_irq got %b exp %b t=%0t", rx_irq, m_irq, $time); end
            if (bad) fails++;
        end
    end

    // ---------------- directed helpers ----------------
    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rx_line = v;
        repeat (16 * tick_div) @(negedge clk);
    endtask

    // Send one frame; flip_par corrupts parity, s1/s2 are the stop levels.
    task automatic send(input logic [7:0] d, input bit flip_par, input logic s1, input logic s2);
        int   n;
        logic p;
        n = cfg_eight_bits ? 8 : 7;
        p = cfg_parity_odd;
        hold_bit(1'b0);
        for (int i = 0; i < n; i++) begin
            hold_bit(d[i]);
            p = p ^ d[i];
        end
        if (cfg_parity_en) hold_bit(p ^ flip_par);
        hold_bit(s1);
        if (cfg_two_stop) hold_bit(s2);
        rx_line = 1'b1;
        repeat (24 * tick_div) @(negedge clk);
    endtask

    task automatic read_buf();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_fmt(input bit eight, input bit pen, input bit podd, input bit two);
        cfg_eight_bits = eight; cfg_parity_en = pen; cfg_parity_odd = podd; cfg_two_stop = two;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 data", rx_data, 8'h00);
        check("R1 flags", {3'b0, buf_full, parity_err, frame_err, overrun_err, rx_irq}, 8'h00);

        // R3: 8N1, least significant bit first
        set_fmt(1, 0, 0, 0);
        send(8'hA5, 0, 1, 1);
        check("R3 data 8N1", rx_data, 8'hA5);
        check("R7 full after frame", {7'b0, buf_full}, 8'h01);
        // R8: read clears full and keeps data
        read_buf();
        check("R8 full cleared", {7'b0, buf_full}, 8'h00);
        check("R8 data kept", rx_data, 8'hA5);

        // R5: even parity good, odd parity corrupted
        set_fmt(1, 1, 0, 0);
        send(8'h3C, 0, 1, 1);
        check("R5 even ok", {7'b0, parity_err}, 8'h00);
        read_buf();
        set_fmt(1, 1, 1, 0);
        send(8'h3C, 1, 1, 1);
        check("R5 odd corrupted", {7'b0, parity_err}, 8'h01);
        check("R5 data", rx_data, 8'h3C);
        read_buf();

        // R4: seven bits, two stops, top bit reads 0
        set_fmt(0, 0, 0, 1);
        send(8'hFF, 0, 1, 1);
        check("R4 seven bit data", rx_data, 8'h7F);
        read_buf();

        // R7: second stop bit low is not checked
        set_fmt(1, 0, 0, 1);
        send(8'h81, 0, 1, 0);
        check("R7 second stop ignored", {7'b0, frame_err}, 8'h00);
        check("R7 data", rx_data, 8'h81);
        read_buf();

        // R6: first stop bit low
        set_fmt(1, 0, 0, 0);
        send(8'h55, 0, 0, 1);
        check("R6 framing", {7'b0, frame_err}, 8'h01);
        read_buf();

        // R2: short low glitch is rejected
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        repeat (64) @(negedge clk);
        check("R2 glitch no byte", {7'b0, buf_full}, 8'h00);
        check("R2 data unchanged", rx_data, 8'h55);

        // R9: overrun keeps the first byte
        send(8'h11, 0, 1, 1);
        send(8'h22, 0, 1, 1);
        check("R9 kept byte", rx_data, 8'h11);
        check("R9 overrun set", {7'b0, overrun_err}, 8'h01);
        read_buf();
        send(8'h33, 0, 1, 1);
        check("R9 overrun cleared", {7'b0, overrun_err}, 8'h00);
        check("R9 next byte", rx_data, 8'h33);

        // R10: read lands on the completion cycle
        fork
            send(8'h44, 0, 1, 1);
            begin
                while (!(m_st == 4 && m_cnt == 15)) @(negedge clk);
                rd = 1'b1;
                @(negedge clk);
                rd = 1'b0;
            end
        join
        check("R10 new byte", rx_data, 8'h44);
        check("R10 no overrun", {7'b0, overrun_err}, 8'h00);
        check("R10 still full", {7'b0, buf_full}, 8'h01);
        read_buf();

        // R11: one tick every three clocks
        tick_div = 3;
        set_fmt(1, 1, 0, 0);
        repeat (6) @(negedge clk);
        send(8'h96, 0, 1, 1);
        check("R11 slow tick data", rx_data, 8'h96);
        check("R11 slow tick parity", {7'b0, parity_err}, 8'h00);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule